// File: doc/BRIEF.md
# Triple Timeout Timer with Test Mode

The block holds three independent timeout counters that serve a bus controller: a selection timer, a general-purpose timer and a handshake timer. The controller starts and stops each counter with strobes. A counter that runs for its programmed number of clocks without being stopped sets a sticky status bit. Each status bit drives an interrupt line through its own enable. The handshake timer also reloads on every request/acknowledge edge while it runs, so it only expires when the bus stalls for a full period.

A write port sets the three periods and a control word that holds the interrupt enables and a test bit. When the test bit is set, all three timers start together. While the bit stays set, every timer uses a short fixed terminal count in place of its programmed period, so all three timeout paths can be exercised in a few clocks. When the test bit is cleared, any running timer stops, and the next start uses the programmed period.

Top module: `tri_timeout_timer`

## Requirements
- R1: After reset all status bits and interrupt outputs are 0 and no timer runs.
- R2: A timer started by its `start_i` bit at clock edge k, with programmed period P (1 or more), sets its status bit at edge k+P, and not before. Periods are written at address 0 (selection, bit 0), address 1 (general, bit 1) and address 2 (handshake, bit 2).
- R3: The three timers run independently. Each one uses its own period and strobes, including when all three are started at the same edge.
- R4: A `stop_i` pulse on a running timer before it expires prevents its timeout.
- R5: While the handshake timer runs, `hs_edge_i` at edge e reloads it, and its status bit sets at edge e+P. An edge that falls in the cycle where the timer would expire wins: no timeout at that edge.
- R6: A programmed period of 0 disables that timer. Starts are ignored and it never times out outside test mode.
- R7: `irq_o[i]` is status bit i AND enable bit i. The enables are bits 2:0 of the control word at address 3.
- R8: Status bits are sticky until a `stat_rd_i` pulse clears them. A timeout that lands on the same edge as the clear leaves its bit set.
- R9: Writing the control word at edge w with bit 3 going from 0 to 1 starts all three timers at edge w+1 with period TEST_CNT. All status bits set at edge w+1+TEST_CNT, whatever periods are programmed.
- R10: Writing bit 3 back to 0 stops every running timer at the write edge. Later starts use the programmed periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0..2 periods, 3 control) |
| wr_data_i | input | CNT_W | Write data |
| start_i | input | 3 | Per-timer start strobes |
| stop_i | input | 3 | Per-timer stop strobes |
| hs_edge_i | input | 1 | Request/acknowledge edge, reloads handshake timer |
| stat_rd_i | input | 1 | Status read, clears status bits |
| stat_o | output | 3 | Sticky timeout status |
| irq_o | output | 3 | Per-timer interrupt |

## Verification
Two pairs of events can land in the same cycle. The first is a status clear and a fresh timeout. The bench starts two timers with periods two cycles apart, lets the short one expire, and pulses the clear exactly on the long one's expiry edge. It expects the old bit gone and the new bit present. The second is a handshake edge and a handshake expiry. The edge offset is swept across the whole period, up to and including the expiry cycle, and each run expects the timeout exactly one period after the last edge.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  localparam int NUM_TMR = 3;
  localparam logic [1:0] ADDR_CTRL = 2'd3;
  localparam int CTRL_TEST_BIT = 3;
  typedef enum int {TMR_SEL = 0, TMR_GEN = 1, TMR_HSH = 2} tmr_e;
endpackage

// File: rtl/ttt_regs.sv
module ttt_regs
  import ttt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [1:0]                      wr_addr_i,
  input  logic [CNT_W-1:0]                wr_data_i,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   period_o,
  output logic [NUM_TMR-1:0]              en_o,
  output logic                            test_o,
  output logic                            test_rise_o,
  output logic                            test_fall_o
);
  logic [NUM_TMR-1:0][CNT_W-1:0] period_q;
  logic [NUM_TMR-1:0]            en_q;
  logic                          test_q, test_d;
  logic                          ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      en_q     <= '0;
      test_q   <= 1'b0;
      test_d   <= 1'b0;
    end else begin
      test_d <= test_q;
      if (ctrl_wr) begin
        en_q   <= wr_data_i[NUM_TMR-1:0];
        test_q <= wr_data_i[CTRL_TEST_BIT];
      end
      for (int i = 0; i < NUM_TMR; i++)
        if (wr_en_i && (wr_addr_i == 2'(i))) period_q[i] <= wr_data_i;
    end
  end

  assign period_o    = period_q;
  assign en_o        = en_q;
  assign test_o      = test_q;
  // start one cycle late so timers already see the short period
  assign test_rise_o = test_q && !test_d;
  // stop on the write edge itself
  assign test_fall_o = ctrl_wr && !wr_data_i[CTRL_TEST_BIT] && test_q;

  assert_ctrl_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> en_o == $past(wr_data_i[NUM_TMR-1:0]));
  assert_test_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_fall_o |=> !test_o);
endmodule

// File: rtl/ttt_unit.sv
module ttt_unit #(
  parameter int CNT_W    = 16,
  parameter int TEST_CNT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             test_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             expire_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] TEST_LD = CNT_W'(TEST_CNT);

  logic [CNT_W-1:0] eff, cnt_q;
  logic             run_q, dis;

  assign eff = test_i ? TEST_LD : period_i;
  assign dis = (eff == '0);
  // >= keeps a shortened period safe against an already advanced count
  assign expire_o = run_q && !dis && !start_i && !stop_i && (cnt_q >= eff - 1'b1);
  assign run_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i || dis) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (expire_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_start_runs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !dis) |=> (run_q && cnt_q == '0));
  assert_stop_halts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q);
  assert_zero_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0 && !test_i) |=> !run_q);
  assert_expire_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !run_q);
endmodule

// File: rtl/tri_timeout_timer.sv
module tri_timeout_timer
  import ttt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TEST_CNT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [NUM_TMR-1:0] start_i,
  input  logic [NUM_TMR-1:0] stop_i,
  input  logic               hs_edge_i,
  input  logic               stat_rd_i,
  output logic [NUM_TMR-1:0] stat_o,
  output logic [NUM_TMR-1:0] irq_o
);
  logic [NUM_TMR-1:0][CNT_W-1:0] period;
  logic [NUM_TMR-1:0]            en, expire, run, t_start, t_stop;
  logic                          test, test_rise, test_fall;
  logic [NUM_TMR-1:0]            stat_q;

  ttt_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_o(period), .en_o(en), .test_o(test),
    .test_rise_o(test_rise), .test_fall_o(test_fall)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    if (g == int'(TMR_HSH)) begin : g_hs
      assign t_start[g] = start_i[g] || test_rise || (hs_edge_i && run[g]);
    end else begin : g_plain
      assign t_start[g] = start_i[g] || test_rise;
    end
    assign t_stop[g] = stop_i[g] || test_fall;

    ttt_unit #(.CNT_W(CNT_W), .TEST_CNT(TEST_CNT)) i_unit (
      .clk_i, .rst_ni,
      .period_i(period[g]), .test_i(test),
      .start_i(t_start[g]), .stop_i(t_stop[g]),
      .expire_o(expire[g]), .run_o(run[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else if (stat_rd_i) stat_q <= expire;
    else stat_q <= stat_q | expire;
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q & en;

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
  assert_rd_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && expire == '0) |=> stat_o == '0);
  assert_test_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_rise && stop_i == '0 && !test_fall) |=> &run);
endmodule

// File: tb/test_tri_timeout_timer.sv
module test_tri_timeout_timer;
  localparam int CNT_W = 16;
  localparam int TC    = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [2:0]        start = '0, stop = '0;
  logic              hs = 1'b0, rd = 1'b0;
  logic [2:0]        stat, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tri_timeout_timer #(.CNT_W(CNT_W), .TEST_CNT(TC)) i_tri_timeout_timer (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .start_i(start), .stop_i(stop), .hs_edge_i(hs), .stat_rd_i(rd),
    .stat_o(stat), .irq_o(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic go(input logic [2:0] m);
    start = m; step(1); start = '0;
  endtask

  task automatic clr();
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    chk("R1 stat", 32'(stat), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2: exact expiry edge for each timer and period
    for (int i = 0; i < 3; i++)
      for (int p = 1; p <= 6; p++) begin
        wr(2'(i), p);
        go(3'(1 << i));
        step(p - 1);
        chk("R2 early", 32'(stat), 0);
        step(1);
        chk("R2 expiry", 32'(stat), 32'(1 << i));
        clr();
      end

    // R3: all three at once
    wr(0, 3); wr(1, 5); wr(2, 7);
    go(3'b111);
    step(2); chk("R3 t2", 32'(stat), 0);
    step(1); chk("R3 t3", 32'(stat), 1);
    step(2); chk("R3 t5", 32'(stat), 3);
    step(2); chk("R3 t7", 32'(stat), 7);
    clr();

    // R4: stop before expiry
    wr(0, 10);
    go(3'b001);
    step(4);
    stop = 3'b001; step(1); stop = '0;
    step(20);
    chk("R4 stopped", 32'(stat), 0);

    // R6: zero period
    wr(1, 0);
    go(3'b010);
    step(20);
    chk("R6 zero", 32'(stat), 0);

    // R5: handshake reload, offset swept up to the expiry cycle
    wr(2, 5);
    for (int d = 0; d < 5; d++) begin
      go(3'b100);
      step(d);
      hs = 1'b1; step(1); hs = 1'b0;
      step(4);
      chk("R5 held", 32'(stat), 0);
      step(1);
      chk("R5 expiry", 32'(stat), 4);
      clr();
    end
    // R5: edge while idle does nothing
    hs = 1'b1; step(1); hs = 1'b0;
    step(10);
    chk("R5 idle", 32'(stat), 0);

    // R8: clear collides with new timeout
    wr(0, 4); wr(1, 2);
    go(3'b011);
    step(3);
    chk("R8 first", 32'(stat), 2);
    rd = 1'b1; step(1); rd = 1'b0;
    chk("R8 set wins", 32'(stat), 1);
    step(5);
    chk("R8 sticky", 32'(stat), 1);
    clr();
    chk("R8 cleared", 32'(stat), 0);

    // R9 + R7: test mode with every enable pattern
    wr(0, 1000); wr(1, 1000); wr(2, 1000);
    for (int en = 0; en < 8; en++) begin
      wr(2'd3, 8 | en);
      step(TC);
      chk("R9 early", 32'(stat), 0);
      step(1);
      chk("R9 all", 32'(stat), 7);
      chk("R7 irq", 32'(irq), 32'(en));
      wr(2'd3, en);
      clr();
      chk("R7 irq off", 32'(irq), 0);
    end

    // R10: leaving test mode stops timers, normal period returns
    wr(2'd3, 8);
    step(5);
    wr(2'd3, 0);
    step(TC + 10);
    chk("R10 stopped", 32'(stat), 0);
    wr(0, 8);
    go(3'b001);
    step(7);
    chk("R10 early", 32'(stat), 0);
    step(1);
    chk("R10 normal", 32'(stat), 1);
    chk("R7 disabled", 32'(irq), 0);
    clr();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule